// File: doc/BRIEF.md
# Multicycle Phase Difference Tracker

This block follows the phase offset between a reference clock and a feedback clock in whole unit intervals. Each clock arrives as a single-cycle edge strobe on the system clock. A signed count records how many reference edges lead or lag the feedback edges. The count carries across many cycles and does not wrap. A large excursion from jitter or wander is therefore kept, not folded back into one cycle.

The tracked range is a symmetric window of plus or minus a programmable limit. The limit can be set anywhere from one UI up to 8191 UI. The count is clamped at either edge of the window, and a flag reports when the count sits on a bound. The tracker runs only while its enable input is high and neither low-rate lock indication is present. In every other case the count is held at zero.

Top module: `mc_phase_tracker`

## Requirements
- R1: While the tracker is active, a reference strobe alone raises `phase_diff` by one and a feedback strobe alone lowers it by one. The new value appears one system clock after the strobe is sampled.
- R2: When both strobes are high in the same cycle, `phase_diff` stays the same.
- R3: The count accumulates over many cycles with no wrap. For example, 100 reference strobes with no feedback strobes give a value of 100.
- R4: `phase_diff` is a 14-bit two's-complement value that never goes above +L or below -L. Here L is the effective limit from `lim_cfg` (13 bits), which ranges from 1 to 8191.
- R5: `sat` is 1 exactly when the registered `phase_diff` equals +L or -L, and 0 otherwise.
- R6: A `lim_cfg` value of 0 is treated as a limit of 1.
- R7: When `trk_en` is 0, `phase_diff` clears to 0 and `sat` goes to 0 on the next clock. Both stay there whatever strobes arrive.
- R8: When `lowrate_lock` is 1, the tracker behaves as disabled, even with `trk_en` at 1.
- R9: When `lock8k_mode` is 1, the tracker behaves as disabled, even with `trk_en` at 1.
- R10: If the limit is lowered below the present magnitude, `phase_diff` is clamped to the new bound on the next clock, even with no strobes.
- R11: A synchronous reset (`rst` = 1) sets `phase_diff` to 0 and `sat` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | 1 | One-cycle strobe per reference clock edge |
| fb_edge | input | 1 | One-cycle strobe per feedback clock edge |
| trk_en | input | 1 | Tracker enable |
| lim_cfg | input | 13 | Range limit in UI (0 is read as 1) |
| lowrate_lock | input | 1 | Direct locking at 8, 4 or 2 kHz; forces the tracker off |
| lock8k_mode | input | 1 | 8 kHz lock mode active; forces the tracker off |
| phase_diff | output | 14 | Signed UI difference, clamped to the limit |
| sat | output | 1 | Count sits on a bound |

## Verification
The bench drives the count to both ends of the full 8191 window. A design that wraps or loses its sign there would show a jump of 16383 instead of a flat clamp. Simultaneous strobes and a zero limit are each exercised: a design that favours one strobe would drift, and one that uses the raw zero limit would pin the count at zero. Lowering the limit while idle catches a design that clamps only when it steps. Each force-off input is applied with strobes present, so a tracker that keeps counting while gated is exposed.

// File: rtl/mcpt_pkg.sv
package mcpt_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/mcpt_step_dec.sv
module mcpt_step_dec
  import mcpt_pkg::*;
(
  input  logic  ref_edge,
  input  logic  fb_edge,
  output step_e step
);
  always_comb begin
    unique case ({ref_edge, fb_edge})
      2'b10:   step = STEP_UP;
      2'b01:   step = STEP_DOWN;
      default: step = STEP_HOLD;
    endcase
  end
endmodule

// File: rtl/mcpt_lim_norm.sv
module mcpt_lim_norm #(
  parameter int LIM_W = 13
) (
  input  logic [LIM_W-1:0] lim_cfg,
  output logic [LIM_W-1:0] lim_eff
);
  localparam logic [LIM_W-1:0] LIM_MIN = LIM_W'(1);

  always_comb begin
    lim_eff = (lim_cfg == '0) ? LIM_MIN : lim_cfg;
  end
endmodule

// File: rtl/mcpt_sat_acc.sv
module mcpt_sat_acc
  import mcpt_pkg::*;
#(
  parameter int LIM_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  step_e              step,
  input  logic [LIM_W-1:0]   lim_eff,
  output logic [LIM_W:0]     diff_q,
  output logic               sat_q
);
  localparam int DW = LIM_W + 1;
  localparam int SW = DW + 1;
  localparam logic signed [SW-1:0] ONE = SW'(1);

  logic signed [SW-1:0] cur_x, sum_x, nxt_x, hi_x, lo_x;
  logic                 sat_d;

  always_comb begin
    cur_x = {diff_q[DW-1], diff_q};
    hi_x  = {2'b00, lim_eff};
    lo_x  = -hi_x;
    unique case (step)
      STEP_UP:   sum_x = cur_x + ONE;
      STEP_DOWN: sum_x = cur_x - ONE;
      default:   sum_x = cur_x;
    endcase
    if (sum_x > hi_x)      nxt_x = hi_x;
    else if (sum_x < lo_x) nxt_x = lo_x;
    else                   nxt_x = sum_x;
    sat_d = (nxt_x == hi_x) || (nxt_x == lo_x);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      diff_q <= '0;
      sat_q  <= 1'b0;
    end else begin
      diff_q <= nxt_x[DW-1:0];
      sat_q  <= sat_d;
    end
  end
endmodule

// File: rtl/mc_phase_tracker.sv
module mc_phase_tracker
  import mcpt_pkg::*;
#(
  parameter int LIM_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_edge,
  input  logic             fb_edge,
  input  logic             trk_en,
  input  logic [LIM_W-1:0] lim_cfg,
  input  logic             lowrate_lock,
  input  logic             lock8k_mode,
  output logic [LIM_W:0]   phase_diff,
  output logic             sat
);
  logic             active;
  step_e            step;
  logic [LIM_W-1:0] lim_eff;

  assign active = trk_en && !lowrate_lock && !lock8k_mode;

  mcpt_step_dec i_dec (
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .step     (step)
  );

  mcpt_lim_norm #(.LIM_W(LIM_W)) i_lim (
    .lim_cfg (lim_cfg),
    .lim_eff (lim_eff)
  );

  mcpt_sat_acc #(.LIM_W(LIM_W)) i_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (!active),
    .step    (step),
    .lim_eff (lim_eff),
    .diff_q  (phase_diff),
    .sat_q   (sat)
  );
endmodule

// File: rtl/mcpt_checker.sv
module mcpt_checker #(
  parameter int LIM_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_edge,
  input logic             fb_edge,
  input logic             trk_en,
  input logic [LIM_W-1:0] lim_cfg,
  input logic             lowrate_lock,
  input logic             lock8k_mode,
  input logic [LIM_W:0]   phase_diff,
  input logic             sat
);
  logic             run;
  logic [LIM_W-1:0] bound;
  logic [LIM_W:0]   mag;

  assign run   = trk_en && !lowrate_lock && !lock8k_mode;
  assign bound = (lim_cfg == '0) ? LIM_W'(1) : lim_cfg;
  assign mag   = phase_diff[LIM_W] ? (~phase_diff + 1'b1) : phase_diff;

  AST_UNIT_UP: assert property (@(posedge clk) disable iff (rst)
    run && ref_edge && !fb_edge && $stable(lim_cfg)
      && ($signed(phase_diff) < $signed({1'b0, bound}))
    |=> phase_diff == $past(phase_diff) + 1'b1); // R1

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    run && ref_edge && fb_edge && $stable(lim_cfg)
    |=> $stable(phase_diff)); // R2

  AST_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    mag <= {1'b0, $past(bound)}); // R4

  AST_SAT_AT_BOUND: assert property (@(posedge clk) disable iff (rst)
    sat |-> mag == {1'b0, $past(bound)}); // R5

  AST_OFF_EN: assert property (@(posedge clk) disable iff (rst)
    !trk_en |=> (phase_diff == '0) && !sat); // R7

  AST_OFF_LOWRATE: assert property (@(posedge clk) disable iff (rst)
    lowrate_lock |=> (phase_diff == '0) && !sat); // R8

  AST_OFF_8K: assert property (@(posedge clk) disable iff (rst)
    lock8k_mode |=> (phase_diff == '0) && !sat); // R9
endmodule

bind mc_phase_tracker mcpt_checker #(.LIM_W(LIM_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .ref_edge     (ref_edge),
  .fb_edge      (fb_edge),
  .trk_en       (trk_en),
  .lim_cfg      (lim_cfg),
  .lowrate_lock (lowrate_lock),
  .lock8k_mode  (lock8k_mode),
  .phase_diff   (phase_diff),
  .sat          (sat)
);

// File: tb/test_mc_phase_tracker.sv
module test_mc_phase_tracker;
  localparam int CLK_P = 10;
  localparam int LW    = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_edge = 1'b0, fb_edge = 1'b0, trk_en = 1'b0;
  logic [LW-1:0] lim_cfg = '0;
  logic          lowrate_lock = 1'b0, lock8k_mode = 1'b0;
  logic [LW:0]   phase_diff;
  logic          sat;

  int checks = 0;
  int errors = 0;
  int md     = 0;
  bit done   = 1'b0;

  typedef struct {
    int    d;
    bit    s;
    string tag;
  } exp_t;
  exp_t sb[$];

  mc_phase_tracker #(.LIM_W(LW)) i_mc_phase_tracker (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .trk_en(trk_en), .lim_cfg(lim_cfg), .lowrate_lock(lowrate_lock),
    .lock8k_mode(lock8k_mode), .phase_diff(phase_diff), .sat(sat)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic drive(input bit r, input bit f, input bit en,
                       input int lim, input bit lr, input bit k8,
                       input string tag);
    int  l;
    bit  act;
    exp_t e;
    @(negedge clk);
    ref_edge = r; fb_edge = f; trk_en = en;
    lim_cfg = LW'(lim); lowrate_lock = lr; lock8k_mode = k8;
    act = en && !lr && !k8;
    l = (lim == 0) ? 1 : lim;
    if (!act) md = 0;
    else begin
      md = md + int'(r) - int'(f);
      if (md > l) md = l;
      if (md < -l) md = -l;
    end
    e.d = md;
    e.s = act && ((md == l) || (md == -l));
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    int   got;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        got = int'($signed(phase_diff));
        checks++;
        if (got != e.d || sat != e.s) begin
          errors++;
          $display("FAIL %s: diff=%0d sat=%0b expected diff=%0d sat=%0b",
                   e.tag, got, sat, e.d, e.s);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    checks++;
    if (phase_diff !== '0 || sat !== 1'b0) begin
      errors++;
      $display("FAIL R11: diff=%0d sat=%0b expected diff=0 sat=0",
               $signed(phase_diff), sat);
    end
    rst = 1'b0;
    // R1: single strobes step by one
    for (int i = 0; i < 5; i++) drive(1, 0, 1, 20, 0, 0, "R1");
    for (int i = 0; i < 2; i++) drive(0, 1, 1, 20, 0, 0, "R1");
    // R2: coincident strobes hold
    for (int i = 0; i < 3; i++) drive(1, 1, 1, 20, 0, 0, "R2");
    // R4: clamp at the positive bound
    for (int i = 0; i < 30; i++) drive(1, 0, 1, 20, 0, 0, "R4");
    drive(1, 1, 1, 20, 0, 0, "R5");
    drive(0, 1, 1, 20, 0, 0, "R5");
    drive(1, 0, 1, 20, 0, 0, "R5");
    // R10: limit lowered while idle
    drive(0, 0, 1, 10, 0, 0, "R10");
    drive(0, 0, 1, 10, 0, 0, "R10");
    // R7: disable clears and holds
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 10, 0, 0, "R7");
    for (int i = 0; i < 3; i++) drive(0, 1, 1, 10, 0, 0, "R4");
    // R8: low-rate lock forces off
    for (int i = 0; i < 4; i++) drive(1, 0, 1, 10, 1, 0, "R8");
    for (int i = 0; i < 2; i++) drive(1, 0, 1, 10, 0, 0, "R1");
    // R9: 8k mode forces off
    for (int i = 0; i < 4; i++) drive(0, 1, 1, 10, 0, 1, "R9");
    // R6: zero limit behaves as one
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) drive(0, 1, 1, 0, 0, 0, "R6");
    drive(0, 0, 0, 0, 0, 0, "R7");
    // R3: long accumulation without wrap, then full-range clamp
    for (int i = 0; i < 100; i++) drive(1, 0, 1, 8191, 0, 0, "R3");
    for (int i = 0; i < 8100; i++) drive(1, 0, 1, 8191, 0, 0, "R4");
    for (int i = 0; i < 16390; i++) drive(0, 1, 1, 8191, 0, 0, "R4");
    drive(1, 0, 1, 8191, 0, 0, "R5");
    drive(0, 0, 0, 8191, 0, 0, "R7");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule